// File: doc/BRIEF.md
# Serial Flash Signature Read and Wake Controller

This block is the command-handling slice of a serial flash slave port that deals with two instructions. The first returns a fixed 8-bit identification byte after an opcode and a run of dummy clocks, and on its completion brings the part out of its low-power sleep state. The second clears the program-failure and erase-failure flags in the status register. Array access, identification beyond the single byte, and multi-lane transfers are handled elsewhere.

All serial pins (chip select, serial clock, serial data in) are brought into the system clock domain through synchronizers, and serial clock edges are detected there. Input bits are taken on serial clock rising edges and output bits are launched on falling edges. The wake delay after a signature read is counted in system clocks, so the delay is set by a parameter and not by analog timing. A busy flag from the array engine blocks the signature read. A sleep-request input puts an idle part to sleep.

Top module: `spi_sig_pd_ctrl`

## Requirements
- R1: After reset the power state is awake (encoding 0), the output enable is low, and status bits 1, 5 and 6 are clear.
- R2: Opcode 0xAB is taken MSB first on the first 8 serial clock rising edges. It is followed by 24 dummy clocks. The output enable stays low for all 32 of these clocks.
- R3: After the 32nd rising edge, each falling edge drives the next signature bit, MSB first. The first bit is valid at the 33rd rising edge.
- R4: While chip select stays low and clocks continue, the signature byte is sent again and again without a gap.
- R5: When the part is asleep (encoding 1) and chip select rises after at least 8 signature clocks, the power state goes to waking (encoding 2). It returns to awake after WAKE_CYCLES system clocks.
- R6: A signature read while awake returns the signature and leaves the power state at awake.
- R7: A signature read decoded while the busy input is high sends nothing and leaves the power state as it was.
- R8: If chip select rises before the dummy clocks are complete, nothing is sent and the part stays asleep.
- R9: Opcode 0x30 clears status bit 5 (erase fail) and bit 6 (program fail) after its 8 clocks. It needs no prior write enable. It leaves bit 1 (write-enable latch) unchanged.
- R10: While asleep or waking, every opcode except 0xAB is ignored. In particular, 0x30 leaves the fail flags set.
- R11: The sleep request is taken only while chip select is high and the busy input is low.
- R12: When asleep, raising chip select after fewer than 8 signature clocks leaves the part asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| arrayBusy | input | 1 | Program, erase or register write in progress; mirrored in status bit 0 |
| dpdReq | input | 1 | Request to enter sleep |
| setWel | input | 1 | Sets the write-enable latch (status bit 1) |
| setEraseFail | input | 1 | Sets the erase-fail flag (status bit 5) |
| setProgFail | input | 1 | Sets the program-fail flag (status bit 6) |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for so; low means high impedance |
| pwrState | output | 2 | 0 awake, 1 asleep, 2 waking |
| statusReg | output | 8 | Status register |

## Verification
The assertions check on every cycle that the output enable is off once chip select has been high for a few clocks, and that waking is entered only from sleep and always leads to awake. They also check that sleep is entered only on a request made while idle and not busy, and that the fail flags fall only while awake. Only the bench's scenarios can show the bit order and timing of the signature, its repetition, the 24-clock dummy count, the exact wake delay, and the effect of busy, early abort and partial reads.

// File: rtl/spi_sig_pkg.sv
package spi_sig_pkg;

  typedef enum logic [1:0] {
    PWR_AWAKE  = 2'd0,
    PWR_ASLEEP = 2'd1,
    PWR_WAKING = 2'd2
  } pwrStateT;

  typedef enum logic [2:0] {
    CS_IDLE  = 3'd0,
    CS_OPC   = 3'd1,
    CS_DUMMY = 3'd2,
    CS_SIG   = 3'd3,
    CS_SKIP  = 3'd4
  } ctrlStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic sigStart;
    logic sigShift;
    logic soRelease;
    logic clrFails;
  } dpStrobeT;

  localparam logic [7:0] OPC_SIG_READ = 8'hAB;
  localparam logic [7:0] OPC_CLR_FAIL = 8'h30;

endpackage

// File: rtl/spi_sig_sync.sv
module spi_sig_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= RESET_VAL;
        else       pipe <= d;
      end
    end else begin : gChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RESET_VAL}};
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_sig_datapath.sv
module spi_sig_datapath
  import spi_sig_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         SIG_W       = 8,
  parameter logic [7:0] SIGNATURE   = 8'h16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       arrayBusy,
  input  logic       setWel,
  input  logic       setEraseFail,
  input  logic       setProgFail,
  input  dpStrobeT   strobe,
  output logic       csActive,
  output logic       sckRise,
  output logic       sckFall,
  output logic [7:0] opcNext,
  output logic       so,
  output logic       soEn,
  output logic [7:0] statusReg
);

  localparam int IDX_W = (SIG_W > 1) ? $clog2(SIG_W) : 1;

  logic csS, sckS, siS, sckQ;
  logic [7:0] opcReg;
  logic [IDX_W-1:0] sigIdx;
  logic soReg, soEnReg;
  logic welQ, eraseFailQ, progFailQ;

  spi_sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .d(csN), .q(csS));
  spi_sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) sckSync_i (
    .clk(clk), .rstN(rstN), .d(sck), .q(sckS));
  spi_sig_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) siSync_i (
    .clk(clk), .rstN(rstN), .d(si), .q(siS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= sckS;
  end

  assign csActive = !csS;
  assign sckRise  = !csS && sckS && !sckQ;
  assign sckFall  = !csS && !sckS && sckQ;
  assign opcNext  = {opcReg[6:0], siS};

  // instruction shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        opcReg <= '0;
    else if (sckRise) opcReg <= opcNext;
  end

  // signature shifter, launched on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigIdx  <= IDX_W'(SIG_W - 1);
      soReg   <= 1'b0;
      soEnReg <= 1'b0;
    end else if (strobe.soRelease) begin
      soReg   <= 1'b0;
      soEnReg <= 1'b0;
    end else if (strobe.sigStart) begin
      sigIdx  <= IDX_W'(SIG_W - 1);
    end else if (strobe.sigShift) begin
      soReg   <= SIGNATURE[sigIdx];
      soEnReg <= 1'b1;
      sigIdx  <= (sigIdx == '0) ? IDX_W'(SIG_W - 1) : sigIdx - 1'b1;
    end
  end

  assign so   = soReg;
  assign soEn = soEnReg;

  // status flags; a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ       <= 1'b0;
      eraseFailQ <= 1'b0;
      progFailQ  <= 1'b0;
    end else begin
      welQ       <= welQ | setWel;
      eraseFailQ <= setEraseFail | (eraseFailQ & !strobe.clrFails);
      progFailQ  <= setProgFail  | (progFailQ  & !strobe.clrFails);
    end
  end

  assign statusReg = {1'b0, progFailQ, eraseFailQ, 3'b000, welQ, arrayBusy};

endmodule

// File: rtl/spi_sig_ctrl.sv
module spi_sig_ctrl
  import spi_sig_pkg::*;
#(
  parameter int WAKE_CYCLES = 64,
  parameter int DUMMY_BYTES = 3,
  parameter int OPC_W       = 8,
  parameter int SIG_W       = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic [7:0] opcNext,
  input  logic       arrayBusy,
  input  logic       dpdReq,
  output dpStrobeT   strobe,
  output pwrStateT   pwrState
);

  localparam int DUMMY_BITS = DUMMY_BYTES * 8;
  localparam int CNT_MAX    = (DUMMY_BITS > OPC_W) ? DUMMY_BITS : OPC_W;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int SIGC_W     = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam int WAKE_W     = $clog2(WAKE_CYCLES + 1);

  ctrlStateT state, stateN;
  pwrStateT  pwr, pwrN;
  logic [CNT_W-1:0]  bitCnt, bitCntN;
  logic [SIGC_W-1:0] sigCnt, sigCntN;
  logic              sigDone, sigDoneN;
  logic [WAKE_W-1:0] wakeCnt, wakeCntN;
  logic              sigHit, clrHit;

  assign sigHit = (opcNext == OPC_SIG_READ);
  assign clrHit = (opcNext == OPC_CLR_FAIL);

  always_comb begin
    stateN   = state;
    pwrN     = pwr;
    bitCntN  = bitCnt;
    sigCntN  = sigCnt;
    sigDoneN = sigDone;
    wakeCntN = wakeCnt;
    strobe   = '0;

    // power sequencing
    case (pwr)
      PWR_AWAKE:
        if (dpdReq && !arrayBusy && !csActive && state == CS_IDLE) pwrN = PWR_ASLEEP;
      PWR_WAKING:
        if (wakeCnt == WAKE_W'(WAKE_CYCLES - 1)) pwrN = PWR_AWAKE;
        else                                     wakeCntN = wakeCnt + 1'b1;
      default: ;
    endcase

    if (!csActive) begin
      if (state != CS_IDLE) begin
        strobe.soRelease = 1'b1;
        if (state == CS_SIG && sigDone && pwr == PWR_ASLEEP) begin
          pwrN     = PWR_WAKING;
          wakeCntN = '0;
        end
      end
      stateN   = CS_IDLE;
      bitCntN  = '0;
      sigDoneN = 1'b0;
    end else begin
      case (state)
        CS_IDLE, CS_OPC: begin
          stateN = CS_OPC;
          if (sckRise) begin
            if (bitCnt == CNT_W'(OPC_W - 1)) begin
              bitCntN = '0;
              if (sigHit && !arrayBusy) begin
                stateN = CS_DUMMY;
              end else begin
                stateN = CS_SKIP;
                if (clrHit && pwr == PWR_AWAKE) strobe.clrFails = 1'b1;
              end
            end else begin
              bitCntN = bitCnt + 1'b1;
            end
          end
        end
        CS_DUMMY: begin
          if (sckRise) begin
            if (bitCnt == CNT_W'(DUMMY_BITS - 1)) begin
              stateN          = CS_SIG;
              strobe.sigStart = 1'b1;
              sigCntN         = '0;
              sigDoneN        = 1'b0;
              bitCntN         = '0;
            end else begin
              bitCntN = bitCnt + 1'b1;
            end
          end
        end
        CS_SIG: begin
          if (sckFall) strobe.sigShift = 1'b1;
          if (sckRise) begin
            sigCntN = (sigCnt == SIGC_W'(SIG_W - 1)) ? '0 : sigCnt + 1'b1;
            if (sigCnt == SIGC_W'(SIG_W - 1)) sigDoneN = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= CS_IDLE;
      pwr     <= PWR_AWAKE;
      bitCnt  <= '0;
      sigCnt  <= '0;
      sigDone <= 1'b0;
      wakeCnt <= '0;
    end else begin
      state   <= stateN;
      pwr     <= pwrN;
      bitCnt  <= bitCntN;
      sigCnt  <= sigCntN;
      sigDone <= sigDoneN;
      wakeCnt <= wakeCntN;
    end
  end

  assign pwrState = pwr;

endmodule

// File: rtl/spi_sig_pd_ctrl.sv
module spi_sig_pd_ctrl
  import spi_sig_pkg::*;
#(
  parameter int         WAKE_CYCLES = 64,
  parameter int         DUMMY_BYTES = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SIGNATURE   = 8'h16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       arrayBusy,
  input  logic       dpdReq,
  input  logic       setWel,
  input  logic       setEraseFail,
  input  logic       setProgFail,
  output logic       so,
  output logic       soEn,
  output logic [1:0] pwrState,
  output logic [7:0] statusReg
);

  localparam int SIG_W = 8;
  localparam int OPC_W = 8;

  dpStrobeT   strobe;
  pwrStateT   pwr;
  logic       csActive, sckRise, sckFall;
  logic [7:0] opcNext;

  spi_sig_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .SIG_W(SIG_W), .SIGNATURE(SIGNATURE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .arrayBusy(arrayBusy), .setWel(setWel), .setEraseFail(setEraseFail),
    .setProgFail(setProgFail), .strobe(strobe), .csActive(csActive),
    .sckRise(sckRise), .sckFall(sckFall), .opcNext(opcNext),
    .so(so), .soEn(soEn), .statusReg(statusReg)
  );

  spi_sig_ctrl #(
    .WAKE_CYCLES(WAKE_CYCLES), .DUMMY_BYTES(DUMMY_BYTES),
    .OPC_W(OPC_W), .SIG_W(SIG_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sckRise(sckRise),
    .sckFall(sckFall), .opcNext(opcNext), .arrayBusy(arrayBusy),
    .dpdReq(dpdReq), .strobe(strobe), .pwrState(pwr)
  );

  assign pwrState = pwr;

endmodule

// File: rtl/spi_sig_checker.sv
module spi_sig_checker
  import spi_sig_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       soEn,
  input logic       arrayBusy,
  input logic       dpdReq,
  input logic [1:0] pwrState,
  input logic [7:0] statusReg
);

  AST_SO_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soEn); // R2

  AST_WAKE_FROM_SLEEP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_WAKING && $past(pwrState) != PWR_WAKING) |-> $past(pwrState) == PWR_ASLEEP); // R5

  AST_WAKE_ENDS_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwrState) == PWR_WAKING && pwrState != PWR_WAKING) |-> pwrState == PWR_AWAKE); // R5

  AST_SLEEP_ENTRY_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == PWR_ASLEEP && $past(pwrState) == PWR_AWAKE) |-> ($past(dpdReq) && !$past(arrayBusy) && $past(csN))); // R11

  AST_PFAIL_CLEAR_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[6]) |-> $past(pwrState) == PWR_AWAKE); // R10

  AST_EFAIL_CLEAR_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[5]) |-> $past(pwrState) == PWR_AWAKE); // R10

  AST_WEL_NOT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[6]) |-> $stable(statusReg[1])); // R9

  AST_PWR_ENCODING: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3); // R1

endmodule

bind spi_sig_pd_ctrl spi_sig_checker chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .soEn(soEn), .arrayBusy(arrayBusy),
  .dpdReq(dpdReq), .pwrState(pwrState), .statusReg(statusReg)
);

// File: tb/spi_sig_pd_ctrl_tb.sv
module spi_sig_pd_ctrl_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam int         HALF       = 6;
  localparam int         WAKE       = 64;
  localparam logic [7:0] SIG_VAL    = 8'h16;

  // {sleepFirst, busy, expectWake, expectSig, opcode[7:0], clocks[7:0]}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 8'hAB, 8'd40},  // R6 awake read
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hAB, 8'd40},  // R5 wake
    {1'b1, 1'b0, 1'b1, 1'b1, 8'hAB, 8'd56},  // R4 repeat
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hAB, 8'd20},  // R8 early abort
    {1'b1, 1'b0, 1'b0, 1'b1, 8'hAB, 8'd36},  // R12 partial byte
    {1'b0, 1'b1, 1'b0, 1'b0, 8'hAB, 8'd48},  // R7 busy awake
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hAB, 8'd48},  // R7 busy asleep
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h30, 8'd8 }   // R10 other opcode asleep
  };

  logic clk = 1'b0;
  logic rstN, csN, sck, si, arrayBusy, dpdReq, setWel, setEraseFail, setProgFail;
  logic so, soEn;
  logic [1:0] pwrState;
  logic [7:0] statusReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_sig_pd_ctrl #(.WAKE_CYCLES(WAKE), .SIGNATURE(SIG_VAL)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .arrayBusy(arrayBusy), .dpdReq(dpdReq), .setWel(setWel),
    .setEraseFail(setEraseFail), .setProgFail(setProgFail),
    .so(so), .soEn(soEn), .pwrState(pwrState), .statusReg(statusReg)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; si = 1'b0; arrayBusy = 1'b0;
    dpdReq = 1'b0; setWel = 1'b0; setEraseFail = 1'b0; setProgFail = 1'b0;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
  endtask

  task automatic pulseSleep();
    dpdReq = 1'b1;
    waitClk(2);
    dpdReq = 1'b0;
    waitClk(2);
  endtask

  task automatic frame(input logic [7:0] opc, input int nClk, input bit expSig,
                       output int quietBad, output int sigBad);
    quietBad = 0;
    sigBad   = 0;
    csN = 1'b0;
    waitClk(8);
    for (int i = 0; i < nClk; i++) begin
      si  = (i < 8) ? opc[7 - i] : 1'b0;
      sck = 1'b0;
      waitClk(HALF);
      if (i < 32 || !expSig) begin
        if (soEn) quietBad++;
      end else begin
        if (!soEn || so !== SIG_VAL[7 - ((i - 32) % 8)]) sigBad++;
      end
      sck = 1'b1;
      waitClk(HALF);
    end
    waitClk(2);
    csN = 1'b1;
    waitClk(4);
    sck = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int qb, sb;
    doReset();

    // R1 reset state
    check(pwrState == 2'd0, "R1", "power after reset", pwrState, 0);
    check(soEn == 1'b0, "R1", "soEn after reset", soEn, 0);
    check(statusReg == 8'h00, "R1", "status after reset", statusReg, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [19:0] e;
      e = VEC[v];
      doReset();
      if (e[19]) begin
        pulseSleep();
        check(pwrState == 2'd1, "R11", "sleep entry", pwrState, 1);
      end
      arrayBusy = e[18];
      frame(e[15:8], int'(e[7:0]), e[16], qb, sb);
      check(qb == 0, "R2", $sformatf("vec %0d quiet phase", v), qb, 0);
      if (e[16]) check(sb == 0, "R3", $sformatf("vec %0d signature bits R4", v), sb, 0);
      waitClk(4);
      if (e[17]) begin
        check(pwrState == 2'd2, "R5", $sformatf("vec %0d waking", v), pwrState, 2);
        waitClk(WAKE - 20);
        check(pwrState == 2'd2, "R5", $sformatf("vec %0d still waking", v), pwrState, 2);
        waitClk(30);
        check(pwrState == 2'd0, "R5", $sformatf("vec %0d awake", v), pwrState, 0);
      end else begin
        waitClk(WAKE + 10);
        check(pwrState == (e[19] ? 2'd1 : 2'd0), "R8",
              $sformatf("vec %0d power held (R6 R7 R12)", v), pwrState, e[19] ? 1 : 0);
      end
      arrayBusy = 1'b0;
    end

    // R9: clear fail flags, keep write-enable latch
    doReset();
    setWel = 1'b1; setEraseFail = 1'b1; setProgFail = 1'b1;
    waitClk(1);
    setWel = 1'b0; setEraseFail = 1'b0; setProgFail = 1'b0;
    waitClk(1);
    check(statusReg == 8'h62, "R9", "flags set", statusReg, 8'h62);
    frame(8'h30, 8, 1'b0, qb, sb);
    check(statusReg == 8'h02, "R9", "fails cleared, WEL kept", statusReg, 8'h02);

    // R9: no write enable needed
    doReset();
    setProgFail = 1'b1;
    waitClk(1);
    setProgFail = 1'b0;
    frame(8'h30, 8, 1'b0, qb, sb);
    check(statusReg == 8'h00, "R9", "clear without WEL", statusReg, 0);

    // R10: clear ignored while asleep
    doReset();
    setEraseFail = 1'b1; setProgFail = 1'b1;
    waitClk(1);
    setEraseFail = 1'b0; setProgFail = 1'b0;
    pulseSleep();
    frame(8'h30, 8, 1'b0, qb, sb);
    check(statusReg == 8'h60, "R10", "flags kept while asleep", statusReg, 8'h60);

    // R11: sleep request gating
    doReset();
    arrayBusy = 1'b1;
    pulseSleep();
    arrayBusy = 1'b0;
    waitClk(2);
    check(pwrState == 2'd0, "R11", "request ignored while busy", pwrState, 0);
    csN = 1'b0;
    waitClk(4);
    pulseSleep();
    csN = 1'b1;
    waitClk(4);
    check(pwrState == 2'd0, "R11", "request ignored while selected", pwrState, 0);
    pulseSleep();
    check(pwrState == 2'd1, "R11", "request taken when idle", pwrState, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule